// File: doc/BRIEF.md
# Centralized Scoreboard Hazard Controller

This block sequences decoded instructions through a set of multi-cycle execution units without renaming or bypass. An instruction presented on the issue port is taken only when its target unit is idle and no earlier instruction still owes a write to the same destination register. Once the instruction is held in its unit's entry, the block waits until both source registers are clean and then grants the unit a one-cycle read of the register file. After the unit reports completion, the block grants writeback only when no other waiting instruction still has to read the old value of that destination.

Each unit has one status entry. The entry holds the busy state, the operation, the destination, both source register numbers, the producing unit of each source and a ready flag for each source. A per-register table records which unit will write each register. A writeback clears the entry and the table slot. The same writeback also marks ready every source that was waiting on that unit. When several units are eligible, one writeback is granted per cycle to the lowest-numbered unit.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: After reset no read or write grant is asserted, and `in_ready` is high for any unit and destination.
- R2: `in_ready` is low while the selected unit holds an instruction, from the issuing clock edge until the edge at which that unit's writeback is granted.
- R3: `in_ready` is low while the requested destination register is owed a write by any issued, not yet written-back instruction.
- R4: If neither source is owed a write at issue, `rd_grant` for that unit rises in the cycle after the issuing edge. `fu_op` bits [u*OP_W +: OP_W] show the issued operation for unit u.
- R5: A source owed a write by unit p holds off `rd_grant` until p's writeback. `rd_grant` rises in the cycle after the edge at which `wr_grant[p]` was high.
- R6: `rd_grant` for a unit is high for exactly one cycle per instruction, and its operands count as read at that edge.
- R7: An `ex_done` pulse to a unit that has read its operands raises `wr_grant` for it in the next cycle, if no hazard holds it back.
- R8: `wr_grant` is withheld while another unit has an unread, ready-flagged source equal to the completing unit's destination. It is granted in the cycle after that reader's `rd_grant`.
- R9: At most one `wr_grant` bit is high per cycle, and among eligible units the lowest index wins.
- R10: In the cycle after a unit's `wr_grant`, the unit and its destination register are free for a new issue.
- R11: A source whose producer is granted writeback in the same cycle as the issue counts as ready, so `rd_grant` follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction may issue this cycle |
| in_unit | input | FU_W | Target execution unit index |
| in_op | input | OP_W | Operation code passed to the unit |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| ex_done | input | NUM_FU | Per-unit completion pulse |
| rd_grant | output | NUM_FU | Per-unit permission to read operands this cycle |
| wr_grant | output | NUM_FU | Per-unit permission to write its result this cycle |
| fu_op | output | NUM_FU*OP_W | Operation held in each unit's entry |

## Verification
All grants come from registered state, so each result is due exactly one clock after the edge that changes it. A read grant follows one cycle after issue or after the producer's writeback. A write grant follows one cycle after the completion pulse or after the blocking reader's grant. A freed unit or destination shows on `in_ready` one cycle after its writeback. The bench drives inputs 2 ns after a rising edge and samples outputs 1 ns later, so each check falls inside the cycle in which the result is due. Negative checks are repeated over more than one cycle to show that a stall holds.

// File: rtl/sb_pkg.sv
package sb_pkg;
   // Lifecycle of one execution-unit entry
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,  // no instruction held
      PH_WAIT = 2'd1,  // issued, operands not yet read
      PH_EXEC = 2'd2,  // operands read, unit computing
      PH_DONE = 2'd3   // result ready, awaiting writeback grant
   } fu_phase_e;
endpackage

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
   import sb_pkg::*;
#(
   parameter int NUM_FU  = 4,
   parameter int NUM_REG = 32,
   parameter int OP_W    = 4,
   localparam int FU_W   = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
   localparam int REG_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_en,
   input  logic [OP_W-1:0]  iss_op,
   input  logic [REG_W-1:0] iss_dst,
   input  logic [REG_W-1:0] iss_src1,
   input  logic [REG_W-1:0] iss_src2,
   input  logic             iss_q1_v,
   input  logic [FU_W-1:0]  iss_q1,
   input  logic             iss_q2_v,
   input  logic [FU_W-1:0]  iss_q2,
   input  logic             rd_take,
   input  logic             ex_done,
   input  logic             wb_take,
   input  logic             bc_v,
   input  logic [FU_W-1:0]  bc_unit,
   output fu_phase_e        phase,
   output logic [OP_W-1:0]  op,
   output logic [REG_W-1:0] dst,
   output logic [REG_W-1:0] src1,
   output logic [REG_W-1:0] src2,
   output logic             rdy1,
   output logic             rdy2
);
   fu_phase_e        phase_q;
   logic [OP_W-1:0]  op_q;
   logic [REG_W-1:0] dst_q, s1_q, s2_q;
   logic [FU_W-1:0]  q1_q, q2_q;
   logic             q1v_q, q2v_q, r1_q, r2_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         op_q    <= '0;
         dst_q   <= '0;
         s1_q    <= '0;
         s2_q    <= '0;
         q1_q    <= '0;
         q2_q    <= '0;
         q1v_q   <= 1'b0;
         q2v_q   <= 1'b0;
         r1_q    <= 1'b0;
         r2_q    <= 1'b0;
      end else if (issue_en) begin
         phase_q <= PH_WAIT;
         op_q    <= iss_op;
         dst_q   <= iss_dst;
         s1_q    <= iss_src1;
         s2_q    <= iss_src2;
         q1_q    <= iss_q1;
         q2_q    <= iss_q2;
         q1v_q   <= iss_q1_v;
         q2v_q   <= iss_q2_v;
         r1_q    <= !iss_q1_v;
         r2_q    <= !iss_q2_v;
      end else if (wb_take) begin
         phase_q <= PH_IDLE;
         q1v_q   <= 1'b0;
         q2v_q   <= 1'b0;
         r1_q    <= 1'b0;
         r2_q    <= 1'b0;
      end else begin
         if (rd_take) begin
            // operands leave the register file; stop blocking later writers
            phase_q <= PH_EXEC;
            r1_q    <= 1'b0;
            r2_q    <= 1'b0;
         end else if (ex_done && phase_q == PH_EXEC) begin
            phase_q <= PH_DONE;
         end
         if (bc_v && q1v_q && q1_q == bc_unit) begin
            q1v_q <= 1'b0;
            r1_q  <= 1'b1;
         end
         if (bc_v && q2v_q && q2_q == bc_unit) begin
            q2v_q <= 1'b0;
            r2_q  <= 1'b1;
         end
      end
   end

   assign phase = phase_q;
   assign op    = op_q;
   assign dst   = dst_q;
   assign src1  = s1_q;
   assign src2  = s2_q;
   assign rdy1  = r1_q;
   assign rdy2  = r2_q;
endmodule

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
   parameter int NUM_FU  = 4,
   parameter int NUM_REG = 32,
   localparam int FU_W   = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
   localparam int REG_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_en,
   input  logic [REG_W-1:0]     set_reg,
   input  logic [FU_W-1:0]      set_unit,
   input  logic                 clr_en,
   input  logic [REG_W-1:0]     clr_reg,
   input  logic [1:0][REG_W-1:0] src_reg,
   output logic [1:0]           src_pend,
   output logic [1:0][FU_W-1:0] src_unit,
   input  logic [REG_W-1:0]     chk_reg,
   output logic                 chk_pend
);
   logic [NUM_REG-1:0]           pend_q;
   logic [NUM_REG-1:0][FU_W-1:0] unit_q;

   for (genvar g = 0; g < NUM_REG; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q[g] <= 1'b0;
            unit_q[g] <= '0;
         end else if (set_en && set_reg == REG_W'(g)) begin
            pend_q[g] <= 1'b1;
            unit_q[g] <= set_unit;
         end else if (clr_en && clr_reg == REG_W'(g)) begin
            pend_q[g] <= 1'b0;
         end
      end
   end

   for (genvar p = 0; p < 2; p++) begin : g_rd
      assign src_pend[p] = pend_q[src_reg[p]];
      assign src_unit[p] = unit_q[src_reg[p]];
   end
   assign chk_pend = pend_q[chk_reg];
endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
   parameter int NUM_FU = 4,
   localparam int FU_W  = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
   input  logic [NUM_FU-1:0] req,
   output logic [NUM_FU-1:0] grant,
   output logic              any,
   output logic [FU_W-1:0]   idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = NUM_FU - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = FU_W'(i);
         end
      end
      grant = '0;
      if (any) grant[idx] = 1'b1;
   end
endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl
   import sb_pkg::*;
#(
   parameter int NUM_FU  = 4,
   parameter int NUM_REG = 32,
   parameter int OP_W    = 4,
   localparam int FU_W   = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
   localparam int REG_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [FU_W-1:0]        in_unit,
   input  logic [OP_W-1:0]        in_op,
   input  logic [REG_W-1:0]       in_dst,
   input  logic [REG_W-1:0]       in_src1,
   input  logic [REG_W-1:0]       in_src2,
   input  logic [NUM_FU-1:0]      ex_done,
   output logic [NUM_FU-1:0]      rd_grant,
   output logic [NUM_FU-1:0]      wr_grant,
   output logic [NUM_FU*OP_W-1:0] fu_op
);
   if (NUM_FU < 2)  begin : g_bad_fu  $error("NUM_FU must be at least 2");  end
   if (NUM_REG < 2) begin : g_bad_reg $error("NUM_REG must be at least 2"); end
   if (OP_W < 1)    begin : g_bad_op  $error("OP_W must be at least 1");    end

   fu_phase_e        ph    [NUM_FU];
   logic [OP_W-1:0]  f_op  [NUM_FU];
   logic [REG_W-1:0] f_dst [NUM_FU];
   logic [REG_W-1:0] f_s1  [NUM_FU];
   logic [REG_W-1:0] f_s2  [NUM_FU];
   logic [NUM_FU-1:0] f_r1, f_r2, busy, war_blk, wb_req;

   logic                  wb_any;
   logic [FU_W-1:0]       wb_idx;
   logic                  fire, unit_ok, dst_pend;
   logic [1:0]            s_pend;
   logic [1:0][FU_W-1:0]  s_unit;
   logic                  q1_v, q2_v;

   // unit index range check only needed when NUM_FU is not a power of two
   if (NUM_FU == (1 << FU_W)) begin : g_full_idx
      assign unit_ok = 1'b1;
   end else begin : g_part_idx
      assign unit_ok = (in_unit < FU_W'(NUM_FU));
   end

   assign in_ready = unit_ok && !busy[in_unit] && !dst_pend;
   assign fire     = in_valid && in_ready;

   // a producer written back this very cycle no longer owes the value
   assign q1_v = s_pend[0] && !(wb_any && s_unit[0] == wb_idx);
   assign q2_v = s_pend[1] && !(wb_any && s_unit[1] == wb_idx);

   sb_reg_status #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) i_regstat (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (fire),
      .set_reg  (in_dst),
      .set_unit (in_unit),
      .clr_en   (wb_any),
      .clr_reg  (f_dst[wb_idx]),
      .src_reg  ({in_src2, in_src1}),
      .src_pend (s_pend),
      .src_unit (s_unit),
      .chk_reg  (in_dst),
      .chk_pend (dst_pend)
   );

   for (genvar u = 0; u < NUM_FU; u++) begin : g_fu
      sb_fu_entry #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG), .OP_W(OP_W)) i_entry (
         .clk      (clk),
         .rst_n    (rst_n),
         .issue_en (fire && in_unit == FU_W'(u)),
         .iss_op   (in_op),
         .iss_dst  (in_dst),
         .iss_src1 (in_src1),
         .iss_src2 (in_src2),
         .iss_q1_v (q1_v),
         .iss_q1   (s_unit[0]),
         .iss_q2_v (q2_v),
         .iss_q2   (s_unit[1]),
         .rd_take  (rd_grant[u]),
         .ex_done  (ex_done[u]),
         .wb_take  (wr_grant[u]),
         .bc_v     (wb_any),
         .bc_unit  (wb_idx),
         .phase    (ph[u]),
         .op       (f_op[u]),
         .dst      (f_dst[u]),
         .src1     (f_s1[u]),
         .src2     (f_s2[u]),
         .rdy1     (f_r1[u]),
         .rdy2     (f_r2[u])
      );
      assign busy[u]                 = (ph[u] != PH_IDLE);
      assign rd_grant[u]             = (ph[u] == PH_WAIT) && f_r1[u] && f_r2[u];
      assign wb_req[u]               = (ph[u] == PH_DONE) && !war_blk[u];
      assign fu_op[u*OP_W +: OP_W]   = f_op[u];
   end

   // WAR: hold a writer while another entry still has to read the old value
   always_comb begin
      war_blk = '0;
      for (int u = 0; u < NUM_FU; u++) begin
         for (int v = 0; v < NUM_FU; v++) begin
            if (u != v) begin
               if ((f_r1[v] && f_s1[v] == f_dst[u]) ||
                   (f_r2[v] && f_s2[v] == f_dst[u]))
                  war_blk[u] = 1'b1;
            end
         end
      end
   end

   sb_wb_arbiter #(.NUM_FU(NUM_FU)) i_arb (
      .req   (wb_req),
      .grant (wr_grant),
      .any   (wb_any),
      .idx   (wb_idx)
   );
endmodule

// File: rtl/sb_hazard_chk.sv
module sb_hazard_chk #(
   parameter int NUM_FU  = 4,
   parameter int NUM_REG = 32,
   localparam int FU_W   = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
   localparam int REG_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [FU_W-1:0]   in_unit,
   input logic [NUM_FU-1:0] rd_grant,
   input logic [NUM_FU-1:0] wr_grant,
   input logic [NUM_FU-1:0] busy,
   input logic [REG_W-1:0]  f_dst [NUM_FU],
   input logic [REG_W-1:0]  f_s1  [NUM_FU],
   input logic [REG_W-1:0]  f_s2  [NUM_FU]
);
   a_r9_wb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_grant));

   for (genvar u = 0; u < NUM_FU; u++) begin : g_u
      a_r2_issue_holds_unit: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_ready && in_unit == FU_W'(u)) |=> busy[u]);

      a_r10_wb_frees_unit: assert property (@(posedge clk) disable iff (!rst_n)
         wr_grant[u] |=> !busy[u]);

      a_r6_read_single: assert property (@(posedge clk) disable iff (!rst_n)
         rd_grant[u] |=> !rd_grant[u]);

      for (genvar v = 0; v < NUM_FU; v++) begin : g_v
         if (u != v) begin : g_pair
            a_r8_no_war: assert property (@(posedge clk) disable iff (!rst_n)
               (wr_grant[u] && rd_grant[v]) |->
                  (f_s1[v] != f_dst[u] && f_s2[v] != f_dst[u]));
         end
      end
   end
endmodule

bind sb_hazard_ctrl sb_hazard_chk #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .in_unit  (in_unit),
   .rd_grant (rd_grant),
   .wr_grant (wr_grant),
   .busy     (busy),
   .f_dst    (f_dst),
   .f_s1     (f_s1),
   .f_s2     (f_s2)
);

// File: tb/test_sb_hazard_ctrl.sv
module test_sb_hazard_ctrl;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic        in_ready;
   logic [1:0]  in_unit;
   logic [3:0]  in_op;
   logic [4:0]  in_dst, in_src1, in_src2;
   logic [3:0]  ex_done;
   logic [3:0]  rd_grant, wr_grant;
   logic [15:0] fu_op;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   sb_hazard_ctrl i_sb_hazard_ctrl (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_unit(in_unit), .in_op(in_op), .in_dst(in_dst), .in_src1(in_src1),
      .in_src2(in_src2), .ex_done(ex_done), .rd_grant(rd_grant),
      .wr_grant(wr_grant), .fu_op(fu_op)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic set_in(input int u, input int op, input int d, input int s1, input int s2);
      in_unit = 2'(u); in_op = 4'(op); in_dst = 5'(d); in_src1 = 5'(s1); in_src2 = 5'(s2);
   endtask

   task automatic do_issue(input int u, input int op, input int d, input int s1, input int s2);
      set_in(u, op, d, s1, s2);
      in_valid = 1'b1;
      #1 chk("R2 issue accepted", 32'(in_ready), 1);
      tick();
      in_valid = 1'b0;
   endtask

   task automatic done_pulse(input logic [3:0] m);
      ex_done = m;
      tick();
      ex_done = '0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; in_valid = 1'b0; ex_done = '0;
      set_in(0, 0, 0, 0, 0);
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk("R1 rd_grant idle", 32'(rd_grant), 0);
      chk("R1 wr_grant idle", 32'(wr_grant), 0);
      set_in(3, 0, 31, 0, 0);
      #1 chk("R1 in_ready after reset", 32'(in_ready), 1);
   endtask

   task automatic t_basic();
      do_issue(0, 5, 5, 1, 2);
      chk("R4 rd_grant after issue", 32'(rd_grant), 1);
      chk("R4 fu_op unit0", 32'(fu_op[3:0]), 5);
      set_in(0, 0, 9, 3, 3);
      #1 chk("R2 busy unit blocks", 32'(in_ready), 0);
      set_in(1, 0, 5, 3, 3);
      #1 chk("R3 pending dst blocks", 32'(in_ready), 0);
      set_in(1, 0, 9, 3, 3);
      #1 chk("R2 other unit free", 32'(in_ready), 1);
      tick();
      chk("R6 read grant single cycle", 32'(rd_grant), 0);
      chk("R7 no write before done", 32'(wr_grant), 0);
      done_pulse(4'b0001);
      chk("R7 write grant after done", 32'(wr_grant), 1);
      tick();
      chk("R7 write grant drops", 32'(wr_grant), 0);
      set_in(0, 0, 5, 3, 3);
      #1 chk("R10 unit and dst freed", 32'(in_ready), 1);
   endtask

   task automatic t_raw();
      do_issue(2, 3, 3, 1, 2);
      chk("R4 producer reads", 32'(rd_grant), 4);
      do_issue(1, 1, 4, 3, 6);
      chk("R5 consumer waits", 32'(rd_grant), 0);
      tick();
      chk("R5 consumer still waits", 32'(rd_grant), 0);
      done_pulse(4'b0100);
      chk("R7 producer write grant", 32'(wr_grant), 4);
      tick();
      chk("R5 consumer reads after writeback", 32'(rd_grant), 2);
      tick();
      done_pulse(4'b0010);
      chk("R7 consumer write grant", 32'(wr_grant), 2);
      tick();
   endtask

   task automatic t_war();
      do_issue(2, 0, 8, 1, 1);
      do_issue(3, 0, 10, 8, 11);
      chk("R5 reader waits on r8", 32'(rd_grant), 0);
      do_issue(1, 0, 11, 1, 2);
      chk("R4 writer of r11 reads", 32'(rd_grant), 2);
      tick();
      done_pulse(4'b0010);
      chk("R8 writeback held", 32'(wr_grant), 0);
      tick();
      chk("R8 writeback still held", 32'(wr_grant), 0);
      done_pulse(4'b0100);
      chk("R8 unblocked unit granted", 32'(wr_grant), 4);
      tick();
      chk("R5 reader released", 32'(rd_grant), 8);
      chk("R8 held until read edge", 32'(wr_grant), 0);
      tick();
      chk("R8 granted after read", 32'(wr_grant), 2);
      tick();
      done_pulse(4'b1000);
      chk("R7 last unit write grant", 32'(wr_grant), 8);
      tick();
   endtask

   task automatic t_prio();
      do_issue(0, 0, 20, 1, 2);
      do_issue(1, 0, 21, 1, 2);
      do_issue(2, 0, 22, 1, 2);
      tick();
      done_pulse(4'b0111);
      chk("R9 lowest first", 32'(wr_grant), 1);
      tick();
      chk("R9 next unit", 32'(wr_grant), 2);
      tick();
      chk("R9 third unit", 32'(wr_grant), 4);
      tick();
      chk("R9 queue empty", 32'(wr_grant), 0);
   endtask

   task automatic t_same_cycle();
      do_issue(0, 0, 12, 1, 1);
      tick();
      done_pulse(4'b0001);
      chk("R7 producer granted", 32'(wr_grant), 1);
      do_issue(1, 0, 13, 12, 12);
      chk("R11 same-cycle release reads", 32'(rd_grant), 2);
      set_in(2, 0, 12, 1, 1);
      #1 chk("R10 dst freed after writeback", 32'(in_ready), 1);
      tick();
      done_pulse(4'b0010);
      chk("R7 consumer granted", 32'(wr_grant), 2);
      tick();
   endtask

   initial begin
      t_reset();
      t_basic();
      t_raw();
      t_war();
      t_prio();
      t_same_cycle();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule